// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block takes 32 level-sensitive hardware request lines and 32 software request bits. It chooses the most urgent pending source and gives a processor a request packet for it. Each source has a control word that holds a 6-bit urgency level, a non-maskable flag and a 6-bit register-set number. A source is pending when its hardware line or its software bit is high and its mask bit is set. Among the pending sources, the one with the highest nonzero level wins. The packet carries a handler address that is computed from a table base and a power-of-two entry size.

Software reaches the block through a plain word-indexed register bus. The mask register and the software-request register each have an OR-in alias and a knock-out alias, so one bit can change without a read-modify-write. The hardware lines are sampled once per clock. The selection and the packet are held in registers, so they follow any change one clock later.

Top module: `vpic_top`

## Requirements
- R1: Reset clears every stored register to 0 (control words, mask, software requests, sampled lines, table base, size selector, status, vector address) and drops `req_valid`.
- R2: Control word of source n sits at index n (0..31). Bit layout: level in bits 5:0, non-maskable flag in bit 6, register set in bits 12:7. Bits 31:13 are not stored and read as 0.
- R3: Index 32 is the mask, written and read in full. A write to index 33 ORs the data into the mask. A write to index 34 clears every mask bit that is 1 in the data.
- R4: Index 37 is the software-request register, written and read in full. Index 38 ORs the data into it and index 39 clears the bits that are set in the data.
- R5: Index 36 reads the sampled hardware lines. Index 35 reads pending = (sampled lines OR software requests) AND mask. Both are read-only.
- R6: The winner is the pending source with the greatest level. A source whose level is 0 never wins, even when it is pending.
- R7: When levels are equal, the lowest-numbered source wins.
- R8: Index 40 bits 2:0 select the entry size, which is 4 << sel bytes. Index 42 is the table base. The handler address is winner × entry size + base, and it reads back at index 43.
- R9: Index 41 reads the winner number with bit 31 set. With no winner, status, vector address and every packet field are 0 and `req_valid` is low.
- R10: When a winner exists, `req_valid` is high and the packet carries the winner's level, register set and non-maskable flag together with the handler address.
- R11: Reads of indices 33, 34, 38, 39 and 44..63 return 0. Writes to 35, 36, 41, 43 and 44..63 change nothing.
- R12: A register write changes the packet one clock after it is captured. A change on a line changes the packet two clocks after it is driven. Read data appears one clock after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Level-sensitive hardware request lines |
| bus_addr | input | 6 | Word index of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after bus_rd |
| req_valid | output | 1 | A winner exists |
| req_handler | output | 32 | Handler address of the winner |
| req_rset | output | 6 | Register set of the winner |
| req_level | output | 6 | Level of the winner |
| req_nmi | output | 1 | Non-maskable flag of the winner |

## Verification
The selection logic is tested with pending sets where every level is zero, where one source clearly outranks the rest, where two sources tie at the same level (low and high indices), and where a higher-level source is masked off. Each of these cases separates strict-greater replacement from other orderings and confirms that masking happens before arbitration. The handler address is checked with the smallest entry size and with large sizes at both low and high winner numbers, which exposes shift-amount and base-add errors. The bench also holds the packet for cycle-exact timing after a register write and after a line edge, because these two paths differ by one sampling stage.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int NUM_SRC = 32;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int LVL_W   = 6;
    localparam int RSET_W  = 6;
    localparam int SEL_W   = 3;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int CFG_W   = LVL_W + 1 + RSET_W;
    localparam int BASE_SHIFT = 2;

    // word indices; control words occupy 0 .. NUM_SRC-1
    localparam logic [ADDR_W-1:0] IX_MASK  = ADDR_W'(NUM_SRC + 0);
    localparam logic [ADDR_W-1:0] IX_MSET  = ADDR_W'(NUM_SRC + 1);
    localparam logic [ADDR_W-1:0] IX_MCLR  = ADDR_W'(NUM_SRC + 2);
    localparam logic [ADDR_W-1:0] IX_PEND  = ADDR_W'(NUM_SRC + 3);
    localparam logic [ADDR_W-1:0] IX_RAW   = ADDR_W'(NUM_SRC + 4);
    localparam logic [ADDR_W-1:0] IX_SWR   = ADDR_W'(NUM_SRC + 5);
    localparam logic [ADDR_W-1:0] IX_SSET  = ADDR_W'(NUM_SRC + 6);
    localparam logic [ADDR_W-1:0] IX_SCLR  = ADDR_W'(NUM_SRC + 7);
    localparam logic [ADDR_W-1:0] IX_SIZE  = ADDR_W'(NUM_SRC + 8);
    localparam logic [ADDR_W-1:0] IX_STAT  = ADDR_W'(NUM_SRC + 9);
    localparam logic [ADDR_W-1:0] IX_BASE  = ADDR_W'(NUM_SRC + 10);
    localparam logic [ADDR_W-1:0] IX_VADDR = ADDR_W'(NUM_SRC + 11);

    typedef struct packed {
        logic [RSET_W-1:0] rset;
        logic              nmi;
        logic [LVL_W-1:0]  lvl;
    } src_cfg_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] handler;
        logic [RSET_W-1:0] rset;
        logic [LVL_W-1:0]  lvl;
        logic              nmi;
    } req_pkt_t;

    function automatic logic [DATA_W-1:0] vec_addr(
        input logic [IDX_W-1:0]  idx,
        input logic [SEL_W-1:0]  sel,
        input logic [DATA_W-1:0] base
    );
        logic [DATA_W-1:0] off;
        off = DATA_W'(idx) << (BASE_SHIFT + int'(sel));
        return off + base;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input pick_t p);
        logic [DATA_W-1:0] w;
        w = '0;
        if (p.valid) begin
            w[DATA_W-1]  = 1'b1;
            w[IDX_W-1:0] = p.idx;
        end
        return w;
    endfunction

endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_SRC-1:0]      irq_lines,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [DATA_W-1:0]       status_q,
    input  logic [DATA_W-1:0]       vaddr_q,
    output src_cfg_t [NUM_SRC-1:0]  cfg_q,
    output logic [NUM_SRC-1:0]      pending,
    output logic [SEL_W-1:0]        sel_q,
    output logic [DATA_W-1:0]       base_q
);

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] swr_q;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] wd_src;
    logic [DATA_W-1:0]  rd_nxt;

    assign wd_src  = bus_wdata[NUM_SRC-1:0];
    assign pending = (raw_q | swr_q) & mask_q;

    // per-source control words
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (bus_wr && bus_addr == ADDR_W'(g)) begin
                cfg_q[g] <= src_cfg_t'(bus_wdata[CFG_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
        end else begin
            raw_q <= irq_lines;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            swr_q  <= '0;
            sel_q  <= '0;
            base_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                IX_MASK: mask_q <= wd_src;
                IX_MSET: mask_q <= mask_q | wd_src;
                IX_MCLR: mask_q <= mask_q & ~wd_src;
                IX_SWR:  swr_q  <= wd_src;
                IX_SSET: swr_q  <= swr_q | wd_src;
                IX_SCLR: swr_q  <= swr_q & ~wd_src;
                IX_SIZE: sel_q  <= bus_wdata[SEL_W-1:0];
                IX_BASE: base_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_nxt = '0;
        if (bus_addr < ADDR_W'(NUM_SRC)) begin
            rd_nxt = DATA_W'(cfg_q[bus_addr[IDX_W-1:0]]);
        end else begin
            unique case (bus_addr)
                IX_MASK:  rd_nxt = DATA_W'(mask_q);
                IX_PEND:  rd_nxt = DATA_W'(pending);
                IX_RAW:   rd_nxt = DATA_W'(raw_q);
                IX_SWR:   rd_nxt = DATA_W'(swr_q);
                IX_SIZE:  rd_nxt = DATA_W'(sel_q);
                IX_STAT:  rd_nxt = status_q;
                IX_BASE:  rd_nxt = base_q;
                IX_VADDR: rd_nxt = vaddr_q;
                default:  rd_nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_nxt;
        end
    end

endmodule

// File: rtl/vpic_pick.sv
module vpic_pick
    import vpic_pkg::*;
(
    input  src_cfg_t [NUM_SRC-1:0] cfg_q,
    input  logic [NUM_SRC-1:0]     pending,
    output pick_t                  pick
);

    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            // strictly greater: earlier index keeps a tie, level 0 never beats 0
            if (pending[i] && cfg_q[i].lvl > pick.lvl) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(i);
                pick.lvl   = cfg_q[i].lvl;
            end
        end
    end

endmodule

// File: rtl/vpic_vec.sv
module vpic_vec
    import vpic_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  pick_t                  pick,
    input  src_cfg_t [NUM_SRC-1:0] cfg_q,
    input  logic [SEL_W-1:0]       sel_q,
    input  logic [DATA_W-1:0]      base_q,
    output req_pkt_t               pkt_q,
    output logic [DATA_W-1:0]      status_q
);

    req_pkt_t pkt_nxt;
    src_cfg_t win_cfg;

    assign win_cfg = cfg_q[pick.idx];

    always_comb begin
        pkt_nxt = '0;
        if (pick.valid) begin
            pkt_nxt.valid   = 1'b1;
            pkt_nxt.handler = vec_addr(pick.idx, sel_q, base_q);
            pkt_nxt.rset    = win_cfg.rset;
            pkt_nxt.lvl     = pick.lvl;
            pkt_nxt.nmi     = win_cfg.nmi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_q    <= '0;
            status_q <= '0;
        end else begin
            pkt_q    <= pkt_nxt;
            status_q <= status_word(pick);
        end
    end

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  irq_lines,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                req_valid,
    output logic [DATA_W-1:0]   req_handler,
    output logic [RSET_W-1:0]   req_rset,
    output logic [LVL_W-1:0]    req_level,
    output logic                req_nmi
);

    src_cfg_t [NUM_SRC-1:0] cfg_q;
    logic [NUM_SRC-1:0]     pending;
    logic [SEL_W-1:0]       sel_q;
    logic [DATA_W-1:0]      base_q;
    logic [DATA_W-1:0]      status_q;
    pick_t                  pick;
    req_pkt_t               pkt_q;

    vpic_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status_q  (status_q),
        .vaddr_q   (pkt_q.handler),
        .cfg_q     (cfg_q),
        .pending   (pending),
        .sel_q     (sel_q),
        .base_q    (base_q)
    );

    vpic_pick u_pick (
        .cfg_q   (cfg_q),
        .pending (pending),
        .pick    (pick)
    );

    vpic_vec u_vec (
        .clk      (clk),
        .rst      (rst),
        .pick     (pick),
        .cfg_q    (cfg_q),
        .sel_q    (sel_q),
        .base_q   (base_q),
        .pkt_q    (pkt_q),
        .status_q (status_q)
    );

    assign req_valid   = pkt_q.valid;
    assign req_handler = pkt_q.handler;
    assign req_rset    = pkt_q.rset;
    assign req_level   = pkt_q.lvl;
    assign req_nmi     = pkt_q.nmi;

endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
    import vpic_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                req_valid,
    input logic [DATA_W-1:0]   req_handler,
    input logic [RSET_W-1:0]   req_rset,
    input logic [LVL_W-1:0]    req_level,
    input logic                req_nmi
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!req_valid && bus_rdata == '0));

    // R6
    live_level_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_level != '0);

    // R9
    idle_packet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (req_handler == '0 && req_level == '0 && req_rset == '0 && !req_nmi));

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr > IX_VADDR) |=> bus_rdata == '0);

    // R3
    mask_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == IX_MCLR && (&bus_wdata[NUM_SRC-1:0])) |=> ##1 !req_valid);

endmodule

bind vpic_top vpic_chk chk_i (.*);

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;
    import vpic_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NUM_SRC-1:0]  irq_lines = '0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic                bus_wr = 1'b0;
    logic                bus_rd = 1'b0;
    logic [DATA_W-1:0]   bus_wdata = '0;
    logic [DATA_W-1:0]   bus_rdata;
    logic                req_valid;
    logic [DATA_W-1:0]   req_handler;
    logic [RSET_W-1:0]   req_rset;
    logic [LVL_W-1:0]    req_level;
    logic                req_nmi;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    logic rd_seen = 1'b0;
    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];

    always #10 clk = ~clk;

    vpic_top dut_i (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_handler(req_handler),
        .req_rset(req_rset), .req_level(req_level), .req_nmi(req_nmi)
    );

    task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected read result per completed read
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("R12 unexpected read", bus_rdata, 32'hDEAD_BEEF);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                      input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_pkt(input string tag, input logic v, input logic [DATA_W-1:0] h,
                           input logic [5:0] lv, input logic [5:0] rs, input logic n);
        chk({tag, " valid"},   DATA_W'(req_valid), DATA_W'(v));
        chk({tag, " handler"}, req_handler, h);
        chk({tag, " level"},   DATA_W'(req_level), DATA_W'(lv));
        chk({tag, " rset"},    DATA_W'(req_rset), DATA_W'(rs));
        chk({tag, " nmi"},     DATA_W'(req_nmi), DATA_W'(n));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 req_valid", DATA_W'(req_valid), 32'd0);
        rd(6'd0,  32'd0, "R1 ctl0");
        rd(6'd32, 32'd0, "R1 mask");
        rd(6'd37, 32'd0, "R1 swreq");
        rd(6'd40, 32'd0, "R1 size");
        rd(6'd41, 32'd0, "R1 status");
        rd(6'd42, 32'd0, "R1 base");
        rd(6'd43, 32'd0, "R1 vaddr");

        // R2 control word storage
        wr(6'd0, 32'hFFFF_FFFF);
        rd(6'd0, 32'h0000_1FFF, "R2 ctl0 stored bits");
        wr(6'd0, 32'd0);

        // R3 mask and aliases
        wr(6'd32, 32'h0000_00F0);
        wr(6'd33, 32'h0000_0003);
        rd(6'd32, 32'h0000_00F3, "R3 mask set alias");
        wr(6'd34, 32'h0000_0030);
        rd(6'd32, 32'h0000_00C3, "R3 mask clear alias");
        rd(6'd33, 32'd0, "R11 set alias reads 0");
        rd(6'd34, 32'd0, "R11 clear alias reads 0");

        // R4 software requests
        wr(6'd37, 32'h0000_0100);
        wr(6'd38, 32'h0000_0001);
        wr(6'd39, 32'h0000_0100);
        rd(6'd37, 32'h0000_0001, "R4 swreq set/clear");
        rd(6'd39, 32'd0, "R11 sw clear alias reads 0");

        // R5 raw and pending; all levels zero so no winner (R6, R9)
        @(negedge clk) irq_lines = 32'h0000_0082;
        settle();
        rd(6'd36, 32'h0000_0082, "R5 raw lines");
        rd(6'd35, 32'h0000_0083, "R5 pending");
        chk_pkt("R6 level zero never wins", 1'b0, 32'd0, 6'd0, 6'd0, 1'b0);
        rd(6'd41, 32'd0, "R9 idle status");
        rd(6'd43, 32'd0, "R9 idle vaddr");

        // R10 single clear winner: src7 lvl5 nmi rset9, src1 lvl3 rset2
        wr(6'd42, 32'h0000_1000);
        wr(6'd7, 32'h0000_04C5);
        wr(6'd1, 32'h0000_0103);
        settle();
        chk_pkt("R10 winner src7", 1'b1, 32'h0000_101C, 6'd5, 6'd9, 1'b1);
        rd(6'd41, 32'h8000_0007, "R9 status src7");
        rd(6'd43, 32'h0000_101C, "R8 vaddr src7 size4");

        // R7 tie at level 5: src0 (sw) beats src7
        wr(6'd0, 32'h0000_0005);
        settle();
        chk_pkt("R7 tie lowest index", 1'b1, 32'h0000_1000, 6'd5, 6'd0, 1'b0);

        // R8 src1 level 63, entry size 32
        wr(6'd1, 32'h0000_013F);
        wr(6'd40, 32'h0000_0003);
        settle();
        chk_pkt("R8 src1 size32", 1'b1, 32'h0000_1020, 6'd63, 6'd2, 1'b0);

        // R5 masked source drops out of arbitration
        wr(6'd34, 32'h0000_0002);
        settle();
        chk_pkt("R5 masked top source", 1'b1, 32'h0000_1000, 6'd5, 6'd0, 1'b0);

        // R11 writes to read-only and unmapped indices
        wr(6'd35, 32'hFFFF_FFFF);
        wr(6'd36, 32'hFFFF_FFFF);
        wr(6'd41, 32'hFFFF_FFFF);
        wr(6'd43, 32'hFFFF_FFFF);
        wr(6'd50, 32'hFFFF_FFFF);
        settle();
        rd(6'd35, 32'h0000_0081, "R11 pending unchanged");
        rd(6'd36, 32'h0000_0082, "R11 raw unchanged");
        rd(6'd41, 32'h8000_0000, "R11 status unchanged");
        rd(6'd43, 32'h0000_1000, "R11 vaddr unchanged");
        rd(6'd50, 32'd0, "R11 unmapped read");
        rd(6'd63, 32'd0, "R11 top index read");

        // R12 write timing: mask wipe seen exactly one clock after capture
        wr(6'd34, 32'hFFFF_FFFF);
        chk("R12 packet before update", DATA_W'(req_valid), 32'd1);
        @(negedge clk);
        chk("R12 packet after write", DATA_W'(req_valid), 32'd0);

        // R12 line timing: two clocks from line edge
        wr(6'd32, 32'hFFFF_FFFF);
        wr(6'd39, 32'hFFFF_FFFF);
        @(negedge clk) irq_lines = '0;
        settle();
        chk("R12 idle before edge", DATA_W'(req_valid), 32'd0);
        irq_lines = 32'h0000_0002;
        @(negedge clk);
        chk("R12 one clock after edge", DATA_W'(req_valid), 32'd0);
        @(negedge clk);
        chk("R12 two clocks after edge", DATA_W'(req_valid), 32'd1);
        chk("R12 level after edge", DATA_W'(req_level), 32'd63);

        // R7 tie at 63: src1 beats src31; R8 then src31 with size 512
        wr(6'd31, 32'h0000_00BF);
        wr(6'd37, 32'h8000_0000);
        wr(6'd40, 32'h0000_0007);
        settle();
        chk_pkt("R7 tie src1 over src31", 1'b1, 32'h0000_1200, 6'd63, 6'd2, 1'b0);
        @(negedge clk) irq_lines = '0;
        settle();
        chk_pkt("R8 src31 size512", 1'b1, 32'h0000_4E00, 6'd63, 6'd1, 1'b0);
        rd(6'd41, 32'h8000_001F, "R9 status src31");

        // R1 reset in mid-run
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", DATA_W'(req_valid), 32'd0);
        rst = 1'b0;
        rd(6'd42, 32'd0, "R1 base after reset");
        rd(6'd31, 32'd0, "R1 ctl31 after reset");

        repeat (3) @(negedge clk);
        chk("R12 read queue drained", DATA_W'(exp_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule